// File: doc/BRIEF.md
# Type-B Contactless Frame Encoder

This block serialises a frame of bytes into the logical bit sequence used on a type-B proximity card link. It emits one line-level bit per etu strobe. A host offers bytes over a valid/ready interface, and a flag marks the final byte of the frame. The host appends the checksum bytes itself. The encoder surrounds the characters with a run of guard ones, a start-of-frame pattern, an end-of-frame pattern and, on the reader side, a run of trailing ones. Each character carries a start bit and a stop bit.

A mode input chooses between the card-side (tag) framing and the reader-side framing. The mode is captured when a frame begins. A frame begins when a byte is offered while the encoder is idle. The first byte is consumed at the end of the start-of-frame pattern. If a byte is missing when the next character is due, the encoder closes the frame at once. Modulation, drive and etu timing generation belong to other blocks.

Top module: `bframe_encoder`

## Requirements
- R1: Out of reset, and between frames, `busy_o` is 0, `line_o` is 1 and `in_ready_o` is 0. A strobe with `in_valid_i` low leaves the block idle.
- R2: A frame starts on the etu strobe at which `in_valid_i` is high while idle, and `busy_o` rises with the first guard bit. `mode_rdr_i` is sampled at that strobe, and later changes do not affect the frame.
- R3: Tag mode (`mode_rdr_i`=0) emits 20 ones, then 10 zeros, then 2 ones before the first character.
- R4: Reader mode (`mode_rdr_i`=1) emits 80 ones, then 11 zeros, before the first character.
- R5: Each character is sent as ten bits: a 0, then the eight data bits with bit 0 first, then a 1.
- R6: In tag mode the frame closes with 10 zeros and then 2 ones, and nothing follows them.
- R7: In reader mode the frame closes with 11 zeros, then 8 ones, then 10 further ones.
- R8: `in_ready_o` is high only in a strobe cycle that emits the final start-of-frame bit or a stop bit. It stays low once a byte flagged with `in_last_i` has been taken. A byte transfers when `in_valid_i` and `in_ready_o` are both high.
- R9: If no byte is offered when a character is due, the next emitted bit is the first end-of-frame zero. This includes a frame that has no characters.
- R10: `line_o` and `busy_o` change only after a clock edge at which `etu_stb_i` was high.
- R11: `busy_o` falls at the strobe after the final trailing bit, and a new frame may then start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_stb_i | input | 1 | One-cycle strobe per bit period |
| mode_rdr_i | input | 1 | 1 = reader framing, 0 = tag framing |
| in_valid_i | input | 1 | Host byte offered |
| in_data_i | input | DATA_W | Host byte |
| in_last_i | input | 1 | Offered byte is the last of the frame |
| in_ready_o | output | 1 | Byte accepted this cycle when valid |
| line_o | output | 1 | Logical line bit for the current etu |
| busy_o | output | 1 | Frame in progress |

## Verification
The hardest state to reach from the ports is a host that runs dry in the middle of a frame. The bench keeps a byte count and withdraws `in_valid_i` after a chosen number of transfers, so the stop bit of a character meets an empty input. The same mechanism covers a frame with no characters. In that case the valid signal is held only until `busy_o` rises, so the end of the start-of-frame pattern finds nothing. A separate case keeps offering bytes after the last-flagged one, to show that the ready signal does not return.

// File: rtl/bframe_pkg.sv
package bframe_pkg;

   typedef enum logic [2:0] {
      SEG_IDLE,
      SEG_PRE,
      SEG_SOF0,
      SEG_SOF1,
      SEG_CHAR,
      SEG_EOF0,
      SEG_EOF1,
      SEG_TAIL
   } seg_e;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bframe_seglen.sv
module bframe_seglen
   import bframe_pkg::*;
#(
   parameter int CW           = 7,
   parameter int CHAR_BITS    = 10,
   parameter int TAG_PRE_LEN  = 20,
   parameter int TAG_SOF0_LEN = 10,
   parameter int TAG_SOF1_LEN = 2,
   parameter int TAG_EOF0_LEN = 10,
   parameter int TAG_EOF1_LEN = 2,
   parameter int TAG_TAIL_LEN = 0,
   parameter int RDR_PRE_LEN  = 80,
   parameter int RDR_SOF0_LEN = 11,
   parameter int RDR_SOF1_LEN = 0,
   parameter int RDR_EOF0_LEN = 11,
   parameter int RDR_EOF1_LEN = 8,
   parameter int RDR_TAIL_LEN = 10
) (
   input  logic          mode_rdr,
   input  seg_e          seg,
   output logic [CW-1:0] len_o,
   output seg_e          nxt_o,
   output logic          lvl_o
);

   int sof1_l, eof1_l, tail_l, cur_l;

   always_comb begin
      sof1_l = mode_rdr ? RDR_SOF1_LEN : TAG_SOF1_LEN;
      eof1_l = mode_rdr ? RDR_EOF1_LEN : TAG_EOF1_LEN;
      tail_l = mode_rdr ? RDR_TAIL_LEN : TAG_TAIL_LEN;
      cur_l  = 1;
      nxt_o  = SEG_IDLE;
      lvl_o  = 1'b1;
      case (seg)
         SEG_IDLE: begin
            nxt_o = SEG_PRE;
         end
         SEG_PRE: begin
            cur_l = mode_rdr ? RDR_PRE_LEN : TAG_PRE_LEN;
            nxt_o = SEG_SOF0;
         end
         SEG_SOF0: begin
            cur_l = mode_rdr ? RDR_SOF0_LEN : TAG_SOF0_LEN;
            nxt_o = (sof1_l > 0) ? SEG_SOF1 : SEG_CHAR;
            lvl_o = 1'b0;
         end
         SEG_SOF1: begin
            cur_l = sof1_l;
            nxt_o = SEG_CHAR;
         end
         SEG_CHAR: begin
            cur_l = CHAR_BITS;
            nxt_o = SEG_EOF0;
         end
         SEG_EOF0: begin
            cur_l = mode_rdr ? RDR_EOF0_LEN : TAG_EOF0_LEN;
            nxt_o = (eof1_l > 0) ? SEG_EOF1 : ((tail_l > 0) ? SEG_TAIL : SEG_IDLE);
            lvl_o = 1'b0;
         end
         SEG_EOF1: begin
            cur_l = eof1_l;
            nxt_o = (tail_l > 0) ? SEG_TAIL : SEG_IDLE;
         end
         SEG_TAIL: begin
            cur_l = tail_l;
            nxt_o = SEG_IDLE;
         end
         default: begin
            nxt_o = SEG_IDLE;
         end
      endcase
      len_o = CW'(cur_l);
   end

endmodule

// File: rtl/bframe_charser.sv
module bframe_charser #(
   parameter int DATA_W = 8,
   localparam int NB    = DATA_W + 2,
   localparam int SW    = $clog2(NB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic [SW-1:0]     sel_i,
   output logic              bit_o
);

   logic [NB-1:0] shreg_q;

   // Character image: stop bit at the top, start bit at index 0.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '1;
      end else if (load_i) begin
         shreg_q <= {1'b1, byte_i, 1'b0};
      end
   end

   always_comb begin
      bit_o = 1'b1;
      if (32'(sel_i) < NB) begin
         bit_o = shreg_q[sel_i];
      end
   end

   // R5
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !shreg_q[0] && shreg_q[NB-1]);

endmodule

// File: rtl/bframe_encoder.sv
module bframe_encoder
   import bframe_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int TAG_PRE_LEN  = 20,
   parameter int TAG_SOF0_LEN = 10,
   parameter int TAG_SOF1_LEN = 2,
   parameter int TAG_EOF0_LEN = 10,
   parameter int TAG_EOF1_LEN = 2,
   parameter int TAG_TAIL_LEN = 0,
   parameter int RDR_PRE_LEN  = 80,
   parameter int RDR_SOF0_LEN = 11,
   parameter int RDR_SOF1_LEN = 0,
   parameter int RDR_EOF0_LEN = 11,
   parameter int RDR_EOF1_LEN = 8,
   parameter int RDR_TAIL_LEN = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              etu_stb_i,
   input  logic              mode_rdr_i,
   input  logic              in_valid_i,
   input  logic [DATA_W-1:0] in_data_i,
   input  logic              in_last_i,
   output logic              in_ready_o,
   output logic              line_o,
   output logic              busy_o
);

   localparam int CHAR_BITS = DATA_W + 2;
   localparam int SW        = $clog2(CHAR_BITS);
   localparam int MAX_TAG   = max_i(max_i(max_i(TAG_PRE_LEN, TAG_SOF0_LEN), max_i(TAG_SOF1_LEN, TAG_EOF0_LEN)),
                                    max_i(TAG_EOF1_LEN, TAG_TAIL_LEN));
   localparam int MAX_RDR   = max_i(max_i(max_i(RDR_PRE_LEN, RDR_SOF0_LEN), max_i(RDR_SOF1_LEN, RDR_EOF0_LEN)),
                                    max_i(RDR_EOF1_LEN, RDR_TAIL_LEN));
   localparam int MAX_LEN   = max_i(max_i(MAX_TAG, MAX_RDR), CHAR_BITS);
   localparam int CW        = $clog2(MAX_LEN + 1);

   // Elaboration-time parameter checks
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("bframe_encoder: DATA_W must be at least 1");
      end
      if (TAG_PRE_LEN < 1 || TAG_SOF0_LEN < 1 || TAG_EOF0_LEN < 1) begin : g_bad_tag
         $error("bframe_encoder: tag guard, SOF zero and EOF zero runs need length >= 1");
      end
      if (RDR_PRE_LEN < 1 || RDR_SOF0_LEN < 1 || RDR_EOF0_LEN < 1) begin : g_bad_rdr
         $error("bframe_encoder: reader guard, SOF zero and EOF zero runs need length >= 1");
      end
      if (TAG_SOF1_LEN < 0 || TAG_EOF1_LEN < 0 || TAG_TAIL_LEN < 0 ||
          RDR_SOF1_LEN < 0 || RDR_EOF1_LEN < 0 || RDR_TAIL_LEN < 0) begin : g_bad_neg
         $error("bframe_encoder: run lengths must not be negative");
      end
   endgenerate

   seg_e          seg_q;
   seg_e          nxt_seg;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] seg_len;
   logic          mode_q;
   logic          last_q;
   logic          seg_lvl;
   logic          char_bit;
   logic          seg_end;
   logic          into_char;
   logic          take;

   bframe_seglen #(
      .CW(CW), .CHAR_BITS(CHAR_BITS),
      .TAG_PRE_LEN(TAG_PRE_LEN), .TAG_SOF0_LEN(TAG_SOF0_LEN), .TAG_SOF1_LEN(TAG_SOF1_LEN),
      .TAG_EOF0_LEN(TAG_EOF0_LEN), .TAG_EOF1_LEN(TAG_EOF1_LEN), .TAG_TAIL_LEN(TAG_TAIL_LEN),
      .RDR_PRE_LEN(RDR_PRE_LEN), .RDR_SOF0_LEN(RDR_SOF0_LEN), .RDR_SOF1_LEN(RDR_SOF1_LEN),
      .RDR_EOF0_LEN(RDR_EOF0_LEN), .RDR_EOF1_LEN(RDR_EOF1_LEN), .RDR_TAIL_LEN(RDR_TAIL_LEN)
   ) u_len (
      .mode_rdr (mode_q),
      .seg      (seg_q),
      .len_o    (seg_len),
      .nxt_o    (nxt_seg),
      .lvl_o    (seg_lvl)
   );

   bframe_charser #(.DATA_W(DATA_W)) u_char (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (take),
      .byte_i (in_data_i),
      .sel_i  (cnt_q[SW-1:0]),
      .bit_o  (char_bit)
   );

   assign seg_end    = (cnt_q == (seg_len - CW'(1)));
   assign into_char  = seg_end && ((seg_q == SEG_CHAR) ? !last_q : (nxt_seg == SEG_CHAR));
   assign in_ready_o = etu_stb_i && (seg_q != SEG_IDLE) && into_char;
   assign take       = in_ready_o && in_valid_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q  <= SEG_IDLE;
         cnt_q  <= '0;
         mode_q <= 1'b0;
         last_q <= 1'b0;
      end else if (etu_stb_i) begin
         if (seg_q == SEG_IDLE) begin
            if (in_valid_i) begin
               seg_q  <= SEG_PRE;
               cnt_q  <= '0;
               mode_q <= mode_rdr_i;
               last_q <= 1'b0;
            end
         end else if (seg_end) begin
            cnt_q <= '0;
            if (take) begin
               seg_q  <= SEG_CHAR;
               last_q <= in_last_i;
            end else if (nxt_seg == SEG_CHAR) begin
               seg_q <= SEG_EOF0;
            end else begin
               seg_q <= nxt_seg;
            end
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign line_o = (seg_q == SEG_CHAR) ? char_bit : seg_lvl;
   assign busy_o = (seg_q != SEG_IDLE);

   // R1
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> line_o && !in_ready_o);

   // R10
   hold_between_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !etu_stb_i |=> $stable(line_o) && $stable(busy_o));

   // R8
   ready_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready_o |-> etu_stb_i && busy_o);

   // R8
   ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_q == SEG_CHAR && last_q) |-> !in_ready_o);

   // R9
   starve_to_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready_o && !in_valid_i) |=> (seg_q == SEG_EOF0) && !line_o);

   // R2
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> (mode_q == $past(mode_q)));

endmodule

// File: tb/bframe_encoder_tb.sv
module bframe_encoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       etu_stb_i = 1'b0;
   logic       mode_rdr_i = 1'b0;
   logic       in_valid_i = 1'b0;
   logic [7:0] in_data_i = 8'h00;
   logic       in_last_i = 1'b0;
   logic       in_ready_o, line_o, busy_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   int cyc_total = 0;

   logic [7:0] fbytes [0:7];
   bit exp_bits [0:1023];
   bit act_bits [0:1023];
   int exp_n, act_n;

   always #5 clk = ~clk;

   bframe_encoder dut_i (
      .clk(clk), .rst_n(rst_n), .etu_stb_i(etu_stb_i), .mode_rdr_i(mode_rdr_i),
      .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
      .in_ready_o(in_ready_o), .line_o(line_o), .busy_o(busy_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_run(input bit v, input int n);
      for (int i = 0; i < n; i++) begin
         exp_bits[exp_n] = v;
         exp_n++;
      end
   endtask

   task automatic build_expect(input bit rdr, input int nb);
      exp_n = 0;
      if (rdr) begin
         push_run(1'b1, 80); push_run(1'b0, 11);
      end else begin
         push_run(1'b1, 20); push_run(1'b0, 10); push_run(1'b1, 2);
      end
      for (int b = 0; b < nb; b++) begin
         push_run(1'b0, 1);
         for (int k = 0; k < 8; k++) push_run(fbytes[b][k], 1);
         push_run(1'b1, 1);
      end
      if (rdr) begin
         push_run(1'b0, 11); push_run(1'b1, 8); push_run(1'b1, 10);
      end else begin
         push_run(1'b0, 10); push_run(1'b1, 2);
      end
   endtask

   // n_last: bytes in frame (last flag on index n_last-1); avail: bytes offered;
   // n_exp: characters expected on the line; flip: toggle mode after start.
   task automatic run_frame(input string req, input bit rdr, input int n_last,
                            input int avail, input int n_exp, input bit flip);
      int  idx = 0;
      int  phase = 0;
      bit  started = 1'b0;
      bit  prev_stb = 1'b0;
      bit  last_line = 1'b1;
      bit  stb;
      int  rdy_viol = 0;
      int  hold_viol = 0;
      int  loops = 0;
      int  first_bad = -1;
      act_n = 0;
      mode_rdr_i = rdr;
      while (loops < 6000) begin
         @(negedge clk);
         loops++;
         if (prev_stb && busy_o) begin
            act_bits[act_n] = line_o;
            act_n++;
         end
         if (!prev_stb && started && (line_o != last_line)) hold_viol++;
         last_line = line_o;
         if (busy_o) started = 1'b1;
         if (started && !busy_o) break;
         stb = (phase == 0);
         phase = (phase + 1) % 4;
         etu_stb_i  = stb;
         in_valid_i = (idx < avail) || !started;
         in_data_i  = fbytes[idx < 8 ? idx : 7];
         in_last_i  = (idx == n_last - 1);
         if (flip && started) mode_rdr_i = ~rdr;
         #1;
         if (in_ready_o && !stb) rdy_viol++;
         if (in_valid_i && in_ready_o) idx++;
         prev_stb = stb;
      end
      etu_stb_i = 1'b0;
      in_valid_i = 1'b0;
      in_last_i = 1'b0;
      mode_rdr_i = 1'b0;
      chk(loops < 6000, {req, " frame completes"}, loops, 6000);
      build_expect(rdr, n_exp);
      chk(act_n == exp_n, {req, " bit count"}, act_n, exp_n);
      for (int i = 0; i < exp_n && i < act_n; i++)
         if (first_bad < 0 && act_bits[i] != exp_bits[i]) first_bad = i;
      chk(first_bad < 0, {req, " first mismatching bit index"}, first_bad, -1);
      chk(idx == n_exp, {req, " bytes taken R8"}, idx, n_exp);
      chk(rdy_viol == 0, {req, " R8 ready outside strobe"}, rdy_viol, 0);
      chk(hold_viol == 0, {req, " R10 line change without strobe"}, hold_viol, 0);
      @(negedge clk);
      chk(!busy_o && line_o && !in_ready_o, {req, " R11 idle after frame"},
          {busy_o, line_o, in_ready_o}, 3'b010);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      etu_stb_i = 1'b1;
      #1;
      chk(!busy_o && line_o && !in_ready_o, "R1 reset state",
          {busy_o, line_o, in_ready_o}, 3'b010);
      @(negedge clk);
      etu_stb_i = 1'b0;
      chk(!busy_o && line_o, "R1 strobe without byte stays idle", {busy_o, line_o}, 2'b01);
   endtask

   task automatic t_tag_one;      // R3 R5 R6
      fbytes[0] = 8'hA5;
      run_frame("R3 R5 R6 tag one byte", 1'b0, 1, 1, 1, 1'b0);
   endtask

   task automatic t_tag_three;    // R5 bit order over several patterns
      fbytes[0] = 8'h01; fbytes[1] = 8'h80; fbytes[2] = 8'h3C;
      run_frame("R5 tag three bytes", 1'b0, 3, 3, 3, 1'b0);
   endtask

   task automatic t_reader_two;   // R4 R7
      fbytes[0] = 8'h06; fbytes[1] = 8'h00;
      run_frame("R4 R7 reader two bytes", 1'b1, 2, 2, 2, 1'b0);
   endtask

   task automatic t_empty;        // R9 zero characters
      run_frame("R9 tag empty frame", 1'b0, 1, 0, 0, 1'b0);
   endtask

   task automatic t_starve;       // R9 host runs dry mid frame
      fbytes[0] = 8'hC3; fbytes[1] = 8'h5A; fbytes[2] = 8'hFF;
      run_frame("R9 reader starve after one", 1'b1, 3, 1, 1, 1'b0);
   endtask

   task automatic t_after_last;   // R8 bytes beyond last are refused
      fbytes[0] = 8'h50; fbytes[1] = 8'h12; fbytes[2] = 8'h34; fbytes[3] = 8'h56;
      run_frame("R8 tag extra bytes after last", 1'b0, 2, 4, 2, 1'b0);
   endtask

   task automatic t_mode_flip;    // R2 mode sampled at start only
      fbytes[0] = 8'h9E;
      run_frame("R2 reader mode toggled mid frame", 1'b1, 1, 1, 1, 1'b1);
      fbytes[0] = 8'h71;
      run_frame("R2 tag mode toggled mid frame", 1'b0, 1, 1, 1, 1'b1);
   endtask

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total > 150000 && !finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_tag_one();
      t_tag_three();
      t_reader_two();
      t_empty();
      t_starve();
      t_after_last();
      t_mode_flip();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule